// File: doc/BRIEF.md
# Two-Tier Priority Arbiter for DMA Channels

This block chooses which of up to sixteen DMA channels the transfer engine serves next. Every channel has a request line and a two-bit priority level. The first tier is strict priority across four levels. The second tier resolves contention inside one level, and software chooses its scheme separately for each level: either the lowest channel number always wins, or the channel that wins rotates using a pointer that the level keeps for itself.

The arbiter presents exactly one channel at a time. A small state machine does this. In state ST_SCAN, grant_valid is low and the block evaluates the requests on every clock. The transition SCAN_TO_OFFER happens on the first edge that sees any pending request; it loads the winner into an output register. In state ST_OFFER, grant_valid is high and the granted channel number is held unchanged (OFFER_HOLD) until the engine raises its accept input. The transition OFFER_TO_SCAN happens on that accepting edge. On the same edge the granting level's round-robin pointer advances, if that level runs round-robin. The self-loop SCAN_IDLE keeps the block in ST_SCAN while nothing is pending.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset, grant_valid is low and every level pointer holds channel 15. The first round-robin search in any level therefore starts at channel 0.
- R2: While no channel is pending in ST_SCAN, grant_valid stays low and no pointer changes.
- R3: The level of channel c is chan_level[2c+1:2c]. Level 3 is the highest. A pending channel at a higher level always wins over every pending channel at a lower level.
- R4: When level_rr[L] is 0 (fixed scheme), the lowest-numbered pending channel at level L wins within that level.
- R5: When level_rr[L] is 1 (round-robin), the search within level L starts at the channel after that level's pointer and wraps from 15 to 0. The first pending channel found wins.
- R6: A level's pointer takes the granted channel number only on an accepted grant from that level while that level is in round-robin. It holds at all other times, including while an offer waits and while other levels are granted.
- R7: While grant_valid is high and eng_accept is low, grant_valid stays high and grant_chan stays stable on the next cycle.
- R8: grant_valid rises on the clock edge that samples a pending request in ST_SCAN. After an accepting edge, grant_valid is low for at least one cycle before the next offer.
- R9: The offered channel was pending on the edge that raised grant_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_req | input | 16 | Pending request per channel |
| chan_level | input | 32 | Two-bit priority level per channel, channel c in bits [2c+1:2c] |
| level_rr | input | 4 | Scheme per level: 1 selects round-robin, 0 selects fixed |
| eng_accept | input | 1 | Transfer engine takes the offered channel |
| grant_valid | output | 1 | A channel is being offered |
| grant_chan | output | 4 | Number of the offered channel |

## Verification
A corrupted level pointer does not appear at the ports right away. It shows only on the next offer from a round-robin level with two or more pending channels, as a grant to the wrong channel number. The bench therefore keeps its own pointers and compares every offer over long mixed sequences. A state machine stuck in ST_OFFER, or one that skips ST_SCAN, shows within one cycle: grant_valid is wrong on the cycle that follows an accept. A wrong level comparison shows on the very first offer in which two levels compete.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int ARB_LEVELS = 4;

    typedef enum logic [0:0] {
        ST_SCAN  = 1'b0,
        ST_OFFER = 1'b1
    } arb_state_e;
endpackage

// File: rtl/dma_lvl_pick.sv
module dma_lvl_pick #(
    parameter int NCH = 16,
    localparam int CW = $clog2(NCH)
) (
    input  logic [NCH-1:0] mask,
    input  logic           rr_mode,
    input  logic [CW-1:0]  ptr,
    output logic           found,
    output logic [CW-1:0]  idx
);
    logic [CW-1:0] start;
    logic [CW-1:0] cand;

    always_comb begin
        start = rr_mode ? ptr + CW'(1) : '0;
        found = 1'b0;
        idx   = '0;
        cand  = '0;
        for (int k = 0; k < NCH; k++) begin
            cand = start + CW'(k);
            if (!found && mask[cand]) begin
                found = 1'b1;
                idx   = cand;
            end
        end
    end

    // R5 / R4: the chosen channel is a member of this level's pending set
    always_comb begin
        if (found) begin
            p_pick_member_r5: assert (mask[idx]);
        end
    end
endmodule

// File: rtl/dma_rr_ptr_bank.sv
module dma_rr_ptr_bank #(
    parameter int NCH  = 16,
    parameter int NLVL = 4,
    localparam int CW = $clog2(NCH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NLVL-1:0]           upd,
    input  logic [CW-1:0]             upd_ch,
    output logic [NLVL-1:0][CW-1:0]   ptr
);
    for (genvar l = 0; l < NLVL; l++) begin : g_ptr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ptr[l] <= CW'(NCH - 1);
            end else if (upd[l]) begin
                ptr[l] <= upd_ch;
            end
        end

        p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !upd[l] |=> $stable(ptr[l]));
    end
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
    import arb_pkg::*;
#(
    parameter int NCH  = 16,
    parameter int NLVL = ARB_LEVELS,
    localparam int CW = $clog2(NCH),
    localparam int LW = $clog2(NLVL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    chan_req,
    input  logic [NCH*LW-1:0] chan_level,
    input  logic [NLVL-1:0]   level_rr,
    input  logic              eng_accept,
    output logic              grant_valid,
    output logic [CW-1:0]     grant_chan
);
    arb_state_e state_q, state_d;

    logic [NLVL-1:0][NCH-1:0] lvl_mask;
    logic [NLVL-1:0]          lvl_found;
    logic [NLVL-1:0][CW-1:0]  lvl_idx;
    logic [NLVL-1:0][CW-1:0]  ptr;
    logic [NLVL-1:0]          ptr_upd;

    logic          win_any;
    logic [CW-1:0] win_ch;
    logic [LW-1:0] win_lvl;
    logic [CW-1:0] gch_q;
    logic [LW-1:0] glvl_q;

    for (genvar l = 0; l < NLVL; l++) begin : g_lvl
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            assign lvl_mask[l][c] = chan_req[c] && (chan_level[c*LW +: LW] == LW'(l));
        end

        dma_lvl_pick #(.NCH(NCH)) u_pick (
            .mask    (lvl_mask[l]),
            .rr_mode (level_rr[l]),
            .ptr     (ptr[l]),
            .found   (lvl_found[l]),
            .idx     (lvl_idx[l])
        );
    end

    // strict tier: higher level index overrides lower
    always_comb begin
        win_any = 1'b0;
        win_ch  = '0;
        win_lvl = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (lvl_found[l]) begin
                win_any = 1'b1;
                win_ch  = lvl_idx[l];
                win_lvl = LW'(l);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SCAN:  if (win_any)    state_d = ST_OFFER;
            ST_OFFER: if (eng_accept) state_d = ST_SCAN;
            default:                  state_d = ST_SCAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SCAN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gch_q  <= '0;
            glvl_q <= '0;
        end else if (state_q == ST_SCAN && win_any) begin
            gch_q  <= win_ch;
            glvl_q <= win_lvl;
        end
    end

    always_comb begin
        ptr_upd = '0;
        if (state_q == ST_OFFER && eng_accept && level_rr[glvl_q])
            ptr_upd[glvl_q] = 1'b1;
    end

    dma_rr_ptr_bank #(.NCH(NCH), .NLVL(NLVL)) u_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .upd    (ptr_upd),
        .upd_ch (gch_q),
        .ptr    (ptr)
    );

    assign grant_valid = (state_q == ST_OFFER);
    assign grant_chan  = gch_q;

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && !eng_accept |=> grant_valid && $stable(grant_chan));

    p_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid && eng_accept |=> !grant_valid);

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid && (chan_req == '0) |=> !grant_valid);

    p_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> ((($past(chan_req) >> grant_chan) & NCH'(1)) != '0));
endmodule

// File: tb/dma_prio_arbiter_test.sv
module dma_prio_arbiter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] chan_req = '0;
    logic [31:0] chan_level = '0;
    logic [3:0]  level_rr = '0;
    logic        eng_accept = 1'b0;
    logic        grant_valid;
    logic [3:0]  grant_chan;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int mptr [4];
    logic [31:0] seed = 32'h1bad_5eed;

    always #10 clk = ~clk;

    dma_prio_arbiter uut (
        .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .chan_level(chan_level),
        .level_rr(level_rr), .eng_accept(eng_accept),
        .grant_valid(grant_valid), .grant_chan(grant_chan)
    );

    function automatic logic [31:0] nxt(logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // reference: returns channel or -1, and its level
    task automatic model(output int ch, output int lv);
        ch = -1;
        lv = -1;
        for (int l = 3; l >= 0 && ch < 0; l--) begin
            int st;
            st = level_rr[l] ? (mptr[l] + 1) % 16 : 0;
            for (int k = 0; k < 16 && ch < 0; k++) begin
                int c;
                c = (st + k) % 16;
                if (chan_req[c] && ((chan_level >> (2*c)) & 3) == l) begin
                    ch = c;
                    lv = l;
                end
            end
        end
    endtask

    // called in ST_SCAN at a negedge with inputs already driven
    task automatic run_one(int hold, string tag);
        int ch, lv;
        model(ch, lv);
        @(negedge clk);
        if (ch < 0) begin
            check("R2 idle", int'(grant_valid), 0);
            return;
        end
        check({tag, " R8 valid"}, int'(grant_valid), 1);
        check(level_rr[lv] ? {tag, " R5 rr"} : {tag, " R4 fixed"}, int'(grant_chan), ch);
        for (int h = 0; h < hold; h++) begin
            chan_req = nxt(seed)[15:0];
            @(negedge clk);
            check("R7 hold", int'(grant_valid) * 16 + int'(grant_chan), 16 + ch);
        end
        eng_accept = 1'b1;
        @(negedge clk);
        eng_accept = 1'b0;
        check("R8 bubble", int'(grant_valid), 0);
        if (level_rr[lv]) mptr[lv] = ch;
    endtask

    initial begin
        for (int l = 0; l < 4; l++) mptr[l] = 15;
        repeat (3) @(negedge clk);
        check("R1 reset valid", int'(grant_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 stay idle", int'(grant_valid), 0);

        // R1: first round-robin search begins at channel 0
        chan_req = 16'hffff; chan_level = '0; level_rr = 4'b0001;
        run_one(0, "R1");
        // R5 wrap: only channel 0 left after pointer at 0 ... then 15 -> 0
        chan_req = 16'h8001;
        run_one(0, "R5 wrap");
        run_one(0, "R5 wrap");
        run_one(0, "R5 wrap");
        // R3: level 3 channel beats many lower ones
        chan_req = 16'h0f0f; chan_level = 32'h00c0_0000; level_rr = 4'b0000;
        run_one(1, "R3");
        // R2: nothing pending keeps idle, and pointers unchanged (checked later by model)
        chan_req = '0;
        run_one(0, "R2");
        run_one(0, "R2");
        // R6: grants at level 2 leave level 1 pointer alone
        chan_level = 32'h5555_5555; chan_level[1:0] = 2'd2; chan_req = 16'h0013; level_rr = 4'b0110;
        run_one(0, "R6");
        run_one(0, "R6");
        chan_req = 16'h0012;
        run_one(0, "R6");
        run_one(0, "R6");

        for (int t = 0; t < 600; t++) begin
            int hold;
            seed = nxt(seed); chan_level = seed;
            seed = nxt(seed); level_rr = seed[3:0]; hold = int'(seed[9:8]) % 3;
            seed = nxt(seed); chan_req = seed[15:0];
            if (seed[20]) chan_req = chan_req & seed[31:16];
            if (seed[21:19] == 3'b000) chan_req = '0;
            run_one(hold, "sweep R3");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule